// File: doc/BRIEF.md
# Power Mode Sequencer

This block moves a processor between four operating modes: Active, Power Save, Idle and Halt. Software programs a byte-wide control/status register. A strobe from the core marks the execution of a wait instruction. A hardware wake-up line, an oscillator-stable flag and an external PLL power-down line complete the inputs. From the register contents and the current mode, the block drives enables for the system clock, the high-frequency oscillator and the PLL.

Mode entry is either immediate or gated by the wait strobe. Power Save may be entered at once. Idle and Halt are always gated by the strobe. Halt powers things down one step per cycle and is left only through a hardware wake-up, which restarts the oscillator and waits for it to settle. A wake-up also clears the mode requests and the oscillator and PLL disable bits.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and all three enables are high. Register bits are: bit0 power-save, bit1 idle, bit2 halt, bit3 wait-gate, bit4 oscillator-disable, bit5 PLL-disable. Bits 7:6 always read 0, and writes to them are ignored.
- R2: With the wait-gate bit clear, writing 1 to bit0 in Active enters Power Save. Bit0 reads 1 only from the second clock edge after the write, once the mode is reached.
- R3: With the wait-gate bit set, a pending power-save request enters Power Save only on the clock edge that samples the wait strobe.
- R4: A set idle bit with the wait-gate bit set enters Idle on the wait strobe. Idle turns the system clock off. With the wait-gate bit clear, a wait strobe leaves the device in Active.
- R5: When requests are pending together at a wait strobe, Halt wins over Idle and Idle wins over Power Save. A wait strobe with no request pending leaves the mode and the enables unchanged.
- R6: On Halt entry the system clock stops on the strobe edge, the PLL stops one cycle later and the oscillator one cycle after that. All three then stay off until a wake-up.
- R7: A wake-up in Halt turns the oscillator on, with the system clock and PLL still off. On the edge that samples oscillator-stable high, the device returns to Active and the halt bit clears.
- R8: A wake-up clears bits 0, 1, 4 and 5 on the next edge and returns Power Save or Idle to Active. Bit3 keeps its value.
- R9: In Power Save and Idle, bit4 set turns the oscillator off and bit5 set turns the PLL off. In Active both bits have no effect on the enables.
- R10: The PLL power-down input forces the PLL enable low in every mode and leaves the oscillator enable unchanged.
- R11: Clearing bit0 in Power Save, or bit1 in Idle, by a write returns the device to Active on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| waitStb | input | 1 | One-cycle pulse when the core executes a wait instruction |
| wakeUp | input | 1 | Hardware wake-up event |
| oscStable | input | 1 | Oscillator has settled |
| pllPwrDown | input | 1 | External PLL power-down |
| sysClkEn | output | 1 | System clock enable |
| oscEn | output | 1 | High-frequency oscillator enable |
| pllEn | output | 1 | PLL enable |

## Verification
The hardest situation to reach is the window inside Halt between the wake-up and oscillator-stable. There the oscillator runs while the system clock and PLL must stay off, and the halt bit is still set. The stimulus reaches it in several steps. It sets the wait-gate and halt bits, pulses the wait strobe, and walks the three shutdown cycles. It then pulses wake-up while holding oscillator-stable low for several cycles, and raises oscillator-stable only after that. The priority cases are reached the same way, by setting several request bits in one write before a single wait strobe.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int REG_W  = 8;
  localparam int B_PS   = 0;
  localparam int B_IDLE = 1;
  localparam int B_HALT = 2;
  localparam int B_GATE = 3;
  localparam int B_DOSC = 4;
  localparam int B_DPLL = 5;
  localparam int USED_W = B_DPLL + 1;

  typedef enum logic [2:0] {
    MODE_ACTIVE    = 3'd0,
    MODE_SAVE      = 3'd1,
    MODE_IDLE      = 3'd2,
    MODE_HALT_CLK  = 3'd3,
    MODE_HALT_PLL  = 3'd4,
    MODE_HALT_OSC  = 3'd5,
    MODE_HALT_WAKE = 3'd6
  } modeE;

  typedef struct packed {
    logic clrWake;
    logic clrHalt;
  } seqStrobeT;

  typedef struct packed {
    logic psPend;
    logic idleReq;
    logic haltReq;
    logic waitGate;
    logic oscOff;
    logic pllOff;
  } cfgT;
endpackage

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_mode_pkg::*;
#(
  parameter int RegW = REG_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [RegW-1:0] wrData,
  input  seqStrobeT       strobe,
  input  logic            inSave,
  output cfgT             cfg,
  output logic [RegW-1:0] rdData
);
  localparam int ResW = RegW - USED_W;

  logic unusedResBits;
  assign unusedResBits = ^wrData[RegW-1:USED_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else begin
      if (wrEn) begin
        cfg.psPend   <= wrData[B_PS];
        cfg.idleReq  <= wrData[B_IDLE];
        cfg.haltReq  <= wrData[B_HALT];
        cfg.waitGate <= wrData[B_GATE];
        cfg.oscOff   <= wrData[B_DOSC];
        cfg.pllOff   <= wrData[B_DPLL];
      end
      if (strobe.clrWake) begin
        cfg.psPend  <= 1'b0;
        cfg.idleReq <= 1'b0;
        cfg.oscOff  <= 1'b0;
        cfg.pllOff  <= 1'b0;
      end
      if (strobe.clrHalt) begin
        cfg.haltReq <= 1'b0;
      end
    end
  end

  logic [USED_W-1:0] usedBits;
  always_comb begin
    usedBits         = '0;
    usedBits[B_PS]   = inSave;
    usedBits[B_IDLE] = cfg.idleReq;
    usedBits[B_HALT] = cfg.haltReq;
    usedBits[B_GATE] = cfg.waitGate;
    usedBits[B_DOSC] = cfg.oscOff;
    usedBits[B_DPLL] = cfg.pllOff;
  end

  generate
    for (genvar i = 0; i < RegW; i++) begin : g_rd
      if (i < USED_W) begin : g_used
        assign rdData[i] = usedBits[i];
      end else begin : g_res
        assign rdData[i] = 1'b0;
      end
    end
  endgenerate

  if (ResW < 0) begin : g_badw
    $error("register narrower than the defined fields");
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  cfgT       cfg,
  input  logic      waitStb,
  input  logic      wakeUp,
  input  logic      oscStable,
  output modeE      mode,
  output seqStrobeT strobe
);
  modeE nextMode;

  always_comb begin
    nextMode       = mode;
    strobe.clrWake = wakeUp;
    strobe.clrHalt = 1'b0;
    unique case (mode)
      MODE_ACTIVE: begin
        if (!wakeUp) begin
          if (cfg.waitGate) begin
            if (waitStb) begin
              if (cfg.haltReq)      nextMode = MODE_HALT_CLK;
              else if (cfg.idleReq) nextMode = MODE_IDLE;
              else if (cfg.psPend)  nextMode = MODE_SAVE;
            end
          end else if (cfg.psPend) begin
            nextMode = MODE_SAVE;
          end
        end
      end
      MODE_SAVE: begin
        if (wakeUp || !cfg.psPend) nextMode = MODE_ACTIVE;
      end
      MODE_IDLE: begin
        if (wakeUp || !cfg.idleReq) nextMode = MODE_ACTIVE;
      end
      MODE_HALT_CLK: begin
        nextMode = wakeUp ? MODE_HALT_WAKE : MODE_HALT_PLL;
      end
      MODE_HALT_PLL: begin
        nextMode = wakeUp ? MODE_HALT_WAKE : MODE_HALT_OSC;
      end
      MODE_HALT_OSC: begin
        if (wakeUp) nextMode = MODE_HALT_WAKE;
      end
      MODE_HALT_WAKE: begin
        if (oscStable) begin
          nextMode       = MODE_ACTIVE;
          strobe.clrHalt = 1'b1;
        end
      end
      default: nextMode = MODE_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) mode <= MODE_ACTIVE;
    else       mode <= nextMode;
  end
endmodule

// File: rtl/pwr_mode_clkdec.sv
module pwr_mode_clkdec
  import pwr_mode_pkg::*;
(
  input  modeE mode,
  input  logic oscOff,
  input  logic pllOff,
  input  logic pllPwrDown,
  output logic sysClkEn,
  output logic oscEn,
  output logic pllEn
);
  logic pllWant;

  always_comb begin
    sysClkEn = 1'b0;
    oscEn    = 1'b0;
    pllWant  = 1'b0;
    unique case (mode)
      MODE_ACTIVE: begin
        sysClkEn = 1'b1;
        oscEn    = 1'b1;
        pllWant  = 1'b1;
      end
      MODE_SAVE: begin
        sysClkEn = 1'b1;
        oscEn    = !oscOff;
        pllWant  = !pllOff;
      end
      MODE_IDLE: begin
        oscEn   = !oscOff;
        pllWant = !pllOff;
      end
      MODE_HALT_CLK: begin
        oscEn   = 1'b1;
        pllWant = 1'b1;
      end
      MODE_HALT_PLL:  oscEn = 1'b1;
      MODE_HALT_OSC:  oscEn = 1'b0;
      MODE_HALT_WAKE: oscEn = 1'b1;
      default: begin
        sysClkEn = 1'b1;
        oscEn    = 1'b1;
        pllWant  = 1'b1;
      end
    endcase
    pllEn = pllWant && !pllPwrDown;
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             waitStb,
  input  logic             wakeUp,
  input  logic             oscStable,
  input  logic             pllPwrDown,
  output logic             sysClkEn,
  output logic             oscEn,
  output logic             pllEn
);
  cfgT       cfg;
  modeE      curMode;
  seqStrobeT strobe;

  pwr_mode_regs #(.RegW(REG_W)) i_regs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .strobe (strobe),
    .inSave (curMode == MODE_SAVE),
    .cfg    (cfg),
    .rdData (rdData)
  );

  pwr_mode_fsm i_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .cfg       (cfg),
    .waitStb   (waitStb),
    .wakeUp    (wakeUp),
    .oscStable (oscStable),
    .mode      (curMode),
    .strobe    (strobe)
  );

  pwr_mode_clkdec i_dec (
    .mode       (curMode),
    .oscOff     (cfg.oscOff),
    .pllOff     (cfg.pllOff),
    .pllPwrDown (pllPwrDown),
    .sysClkEn   (sysClkEn),
    .oscEn      (oscEn),
    .pllEn      (pllEn)
  );
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk
  import pwr_mode_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             wakeUp,
  input logic             oscStable,
  input logic             pllPwrDown,
  input logic [REG_W-1:0] rdData,
  input logic             sysClkEn,
  input logic             oscEn,
  input logic             pllEn,
  input modeE             curMode
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    rdData[REG_W-1:USED_W] == '0);

  assert_halt_pll_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    curMode == MODE_HALT_PLL |-> $past(curMode) == MODE_HALT_CLK);

  assert_halt_osc_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    curMode == MODE_HALT_OSC |-> ($past(curMode) == MODE_HALT_PLL || $past(curMode) == MODE_HALT_OSC));

  assert_halt_all_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    curMode == MODE_HALT_OSC |-> (!sysClkEn && !oscEn && !pllEn));

  assert_wake_osc_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    curMode == MODE_HALT_WAKE |-> (oscEn && !sysClkEn && !pllEn));

  assert_halt_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_HALT_WAKE && oscStable) |=> (curMode == MODE_ACTIVE && !rdData[B_HALT]));

  assert_wake_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |=> (!rdData[B_PS] && !rdData[B_IDLE] && !rdData[B_DOSC] && !rdData[B_DPLL]));

  assert_active_all_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    curMode == MODE_ACTIVE |-> (sysClkEn && oscEn && (pllEn == !pllPwrDown)));

  assert_pll_forced_R10: assert property (@(posedge clk) disable iff (!rstN)
    pllPwrDown |-> !pllEn);
endmodule

bind pwr_mode_ctrl pwr_mode_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wakeUp     (wakeUp),
  .oscStable  (oscStable),
  .pllPwrDown (pllPwrDown),
  .rdData     (rdData),
  .sysClkEn   (sysClkEn),
  .oscEn      (oscEn),
  .pllEn      (pllEn),
  .curMode    (curMode)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       waitStb = 1'b0;
  logic       wakeUp = 1'b0;
  logic       oscStable = 1'b0;
  logic       pllPwrDown = 1'b0;
  logic       sysClkEn, oscEn, pllEn;

  int nChecks = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .waitStb(waitStb), .wakeUp(wakeUp), .oscStable(oscStable),
    .pllPwrDown(pllPwrDown), .sysClkEn(sysClkEn), .oscEn(oscEn), .pllEn(pllEn)
  );

  task automatic chkReg(input string req, input logic [7:0] exp);
    #1;
    nChecks++;
    if (rdData !== exp) begin
      nBad++;
      $display("FAIL %s: rdData actual=%02h expected=%02h", req, rdData, exp);
    end
  endtask

  // enable triple ordered {sysClkEn, oscEn, pllEn}
  task automatic chkEn(input string req, input logic [2:0] exp);
    #1;
    nChecks++;
    if ({sysClkEn, oscEn, pllEn} !== exp) begin
      nBad++;
      $display("FAIL %s: enables actual=%03b expected=%03b", req, {sysClkEn, oscEn, pllEn}, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; waitStb = 1'b0; wakeUp = 1'b0;
    oscStable = 1'b0; pllPwrDown = 1'b0;
    step(3);
    rstN = 1'b1;
  endtask

  task automatic wrReg(input logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic pulseWait();
    waitStb = 1'b1; step(); waitStb = 1'b0;
  endtask

  task automatic pulseWake();
    wakeUp = 1'b1; step(); wakeUp = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    chkReg("R1 reset value", 8'h00);
    chkEn("R1 reset enables", 3'b111);
    wrReg(8'hFF);
    chkReg("R1 reserved bits read zero", 8'h3E);
    step();
    chkEn("R1 no mode change without wait", 3'b111);
  endtask

  task automatic testImmediateSave();
    doReset();
    wrReg(8'h01);
    chkReg("R2 status not yet set", 8'h00);
    step();
    chkReg("R2 status set after switch", 8'h01);
    chkEn("R2 save enables", 3'b111);
    wrReg(8'h00);
    chkReg("R11 still in save on write edge", 8'h01);
    step();
    chkReg("R11 back to active", 8'h00);
  endtask

  task automatic testDeferredSave();
    doReset();
    wrReg(8'h09);
    step(3);
    chkReg("R3 held until wait", 8'h08);
    pulseWait();
    chkReg("R3 save after wait", 8'h09);
  endtask

  task automatic testIdle();
    doReset();
    wrReg(8'h02);
    pulseWait();
    chkEn("R4 idle ignored without gate", 3'b111);
    wrReg(8'h0A);
    pulseWait();
    chkReg("R4 idle bit", 8'h0A);
    chkEn("R4 idle gates system clock", 3'b011);
    wrReg(8'h08);
    step();
    chkEn("R11 idle cleared returns active", 3'b111);
  endtask

  task automatic testPriority();
    doReset();
    wrReg(8'h08);
    pulseWait();
    chkReg("R5 empty wait register", 8'h08);
    chkEn("R5 empty wait enables", 3'b111);
    wrReg(8'h0B);
    pulseWait();
    chkReg("R5 idle over save", 8'h0A);
    chkEn("R5 idle over save enables", 3'b011);
    doReset();
    wrReg(8'h0F);
    pulseWait();
    chkEn("R5 halt wins", 3'b011);
    chkReg("R5 halt wins status", 8'h0E);
  endtask

  task automatic testHalt();
    doReset();
    wrReg(8'h0C);
    pulseWait();
    chkEn("R6 step1 clock off", 3'b011);
    step();
    chkEn("R6 step2 pll off", 3'b010);
    step();
    chkEn("R6 step3 osc off", 3'b000);
    step(2);
    chkEn("R6 stays off", 3'b000);
    chkReg("R6 halt bit held", 8'h0C);
    pulseWake();
    chkEn("R7 osc restarts only", 3'b010);
    step(3);
    chkEn("R7 waits for stable", 3'b010);
    chkReg("R7 halt bit still set", 8'h0C);
    oscStable = 1'b1;
    step();
    oscStable = 1'b0;
    chkEn("R7 active after stable", 3'b111);
    chkReg("R7 halt bit cleared", 8'h08);
  endtask

  task automatic testDisables();
    doReset();
    wrReg(8'h38);
    chkEn("R9 no effect in active", 3'b111);
    wrReg(8'h39);
    pulseWait();
    chkReg("R9 save with disables", 8'h39);
    chkEn("R9 osc and pll off in save", 3'b100);
    pulseWake();
    chkReg("R8 wake clears bits", 8'h08);
    chkEn("R8 wake restores enables", 3'b111);
    doReset();
    wrReg(8'h11);
    step();
    chkEn("R9 osc-only disable", 3'b101);
  endtask

  task automatic testPllDown();
    doReset();
    pllPwrDown = 1'b1;
    chkEn("R10 active pll forced off", 3'b110);
    wrReg(8'h21);
    step();
    chkEn("R10 save pll off", 3'b110);
    pllPwrDown = 1'b0;
    chkEn("R9 pll disable in save", 3'b110);
    wrReg(8'h00);
    step();
    chkEn("R11 save exit", 3'b111);
  endtask

  initial begin
    #(200000 * 5);
    nChecks++;
    nBad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    testReset();
    testImmediateSave();
    testDeferredSave();
    testIdle();
    testPriority();
    testHalt();
    testDisables();
    testPllDown();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule